// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block connects a simple 32-bit register bus to an external analog-to-digital converter core. Software programs a control word: input channel, reference source, interrupt enable, converter enable and a clock divider. It then requests one conversion by setting the conversion bit. The block latches the channel and starts the converter, then holds the start line high until the converter reports completion. On completion it stores the sample in a result register, drops the conversion bit and raises a sticky status flag that can drive an interrupt line.

The converter runs from a divided clock that this block produces. The output period is (div+1)*2 input cycles. A soft-reset bit in the control word abandons a conversion that never completes. It does so without disturbing the rest of the configuration. The analog core itself lies outside the block.

Top module: `adc_conv_ctrl`

## Requirements
- R1: The control word is at byte address 0x00 and the result at 0x04; any other address reads zero and ignores writes. Control fields read back as last written: channel bits 27:24, interrupt enable bit 21, reference select bit 19, status bit 18, converter enable bit 17, soft reset bit 16, conversion bit 13, divider bits 8:1; every other bit reads zero.
- R2: A control write with bit 13 = 1, bit 17 = 1, bit 16 = 0 and channel < 8, made while idle, makes bit 13 read 1 from the next cycle, raises conv_start_o and presents the channel on conv_ch_o.
- R3: When conv_done_i is high while a conversion runs, at the following edge the result register takes conv_data_i, bit 13 clears, conv_start_o falls and status bit 18 sets.
- R4: Status bit 18 is cleared only by a control write with bit 18 = 1; a write with bit 18 = 0 leaves it. A completion in the same cycle as a clearing write leaves it set. irq_o equals bit 18 AND bit 21.
- R5: A start request is ignored when the written enable bit 17 is 0 or the written channel is 8 or above.
- R6: While enable bit 17 is 1, conv_clk_o toggles every div+1 clock cycles, giving a period of (div+1)*2; while bit 17 is 0 it is held low.
- R7: While soft reset bit 16 is 1, any running conversion is abandoned and bit 13 clears with no result captured. Start requests and conv_done_i are ignored. The other control fields keep their written values.
- R8: While a conversion runs, writing bit 13 (0 or 1) neither stops nor restarts it, and conv_ch_o keeps the channel sampled at start even if the channel field is rewritten.
- R9: If conv_done_i never arrives, bit 13 stays 1 and conv_start_o stays high indefinitely.
- R10: Result bits at and above RES_W read zero. conv_ref_int_o follows bit 19, where 1 selects the internal reference and 0 the external one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| conv_clk_o | output | 1 | Divided converter clock |
| conv_start_o | output | 1 | Conversion in progress / start to converter |
| conv_ch_o | output | 3 | Channel latched at start |
| conv_ref_int_o | output | 1 | 1 selects the internal reference |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | RES_W | Converter sample |

## Verification
The hardest case to reach is a completion that lands in the same clock cycle as a status-clearing write. With a converter that replies on its own, the two events only meet by chance. The bench therefore switches the converter model to manual control. It holds a conversion open, then drives the done pulse and the clearing write in one drive slot. It also holds the converter silent for a long stretch to show a stuck conversion, then releases it with the soft-reset bit. A behavioural model tracks every output and the read data on every clock throughout.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned BIT_IEN  = 21;
  localparam int unsigned BIT_REF  = 19;
  localparam int unsigned BIT_ST   = 18;
  localparam int unsigned BIT_EN   = 17;
  localparam int unsigned BIT_RST  = 16;
  localparam int unsigned BIT_CONV = 13;
  localparam int unsigned CH_LSB   = 24;
  localparam int unsigned CH_W     = 4;
  localparam int unsigned DIV_LSB  = 1;
  localparam int unsigned DIV_W    = 8;
  localparam logic [7:0]  OFS_CTRL = 8'h00;
  localparam logic [7:0]  OFS_RES  = 8'h04;

  typedef struct packed {
    logic [CH_W-1:0]  ch;
    logic             ien;
    logic             ref_int;
    logic             en;
    logic             srst;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_st_e;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q >= div_i) begin
      // >= keeps the count bounded when div shrinks mid-count
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o = clk_q;

  AST_CLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !clk_o); // R6
  AST_CLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q < div_i) |=> $stable(clk_o)); // R6
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned CH_OUT_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic [CH_OUT_W-1:0] ch_i,
  input  logic                done_i,
  input  logic [RES_W-1:0]    data_i,
  output logic                busy_o,
  output logic [CH_OUT_W-1:0] ch_o,
  output logic [RES_W-1:0]    result_o,
  output logic                cap_o
);
  seq_st_e             st_q;
  logic [CH_OUT_W-1:0] ch_q;
  logic [RES_W-1:0]    res_q;

  assign cap_o = (st_q == SEQ_BUSY) && done_i && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      ch_q  <= '0;
      res_q <= '0;
    end else if (abort_i) begin
      st_q <= SEQ_IDLE;
    end else if (cap_o) begin
      st_q  <= SEQ_IDLE;
      res_q <= data_i;
    end else if (st_q == SEQ_IDLE && start_i) begin
      st_q <= SEQ_BUSY;
      ch_q <= ch_i;
    end
  end

  assign busy_o   = (st_q == SEQ_BUSY);
  assign ch_o     = ch_q;
  assign result_o = res_q;

  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i && !abort_i) |=> (!busy_o && result_o == $past(data_i))); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && $stable(result_o))); // R7
  AST_CH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i && !done_i) |=> (busy_o && $stable(ch_o))); // R8
  AST_NO_SELF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o); // R5
endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W    = 10,
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned CH_OUT_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  logic                cap_i,
  input  logic [RES_W-1:0]    result_i,
  output cfg_t                cfg_o,
  output logic                start_o,
  output logic                abort_o,
  output logic [CH_OUT_W-1:0] start_ch_o,
  output logic                irq_o
);
  cfg_t cfg_q, cfg_d;
  logic st_q;
  logic wr_ctrl;
  logic ch_ok;

  assign wr_ctrl = req_i && we_i && (addr_i == OFS_CTRL);
  assign ch_ok   = ({1'b0, wdata_i[CH_LSB +: CH_W]} < (CH_W+1)'(NUM_CH));

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.ch      = wdata_i[CH_LSB +: CH_W];
      cfg_d.ien     = wdata_i[BIT_IEN];
      cfg_d.ref_int = wdata_i[BIT_REF];
      cfg_d.en      = wdata_i[BIT_EN];
      cfg_d.srst    = wdata_i[BIT_RST];
      cfg_d.div     = wdata_i[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  // completion wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        st_q <= 1'b0;
    else if (cap_i)                     st_q <= 1'b1;
    else if (wr_ctrl && wdata_i[BIT_ST]) st_q <= 1'b0;
  end

  assign abort_o    = cfg_d.srst;
  assign start_o    = wr_ctrl && wdata_i[BIT_CONV] && wdata_i[BIT_EN]
                      && !wdata_i[BIT_RST] && ch_ok;
  assign start_ch_o = wdata_i[CH_LSB +: CH_OUT_W];
  assign cfg_o      = cfg_q;
  assign irq_o      = st_q && cfg_q.ien;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTRL) begin
      rdata_o[CH_LSB +: CH_W]   = cfg_q.ch;
      rdata_o[BIT_IEN]          = cfg_q.ien;
      rdata_o[BIT_REF]          = cfg_q.ref_int;
      rdata_o[BIT_ST]           = st_q;
      rdata_o[BIT_EN]           = cfg_q.en;
      rdata_o[BIT_RST]          = cfg_q.srst;
      rdata_o[BIT_CONV]         = busy_i;
      rdata_o[DIV_LSB +: DIV_W] = cfg_q.div;
    end else if (addr_i == OFS_RES) begin
      rdata_o[RES_W-1:0] = result_i;
    end
  end

  AST_FLAG_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> st_q); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q && !(wr_ctrl && wdata_i[BIT_ST])) |=> st_q); // R4
  AST_FIELDS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned NUM_CH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [7:0]                 addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic                       irq_o,
  output logic                       conv_clk_o,
  output logic                       conv_start_o,
  output logic [$clog2(NUM_CH)-1:0]  conv_ch_o,
  output logic                       conv_ref_int_o,
  input  logic                       conv_done_i,
  input  logic [RES_W-1:0]           conv_data_i
);
  localparam int unsigned CH_OUT_W = $clog2(NUM_CH);

  cfg_t                cfg;
  logic                start, abort, busy, cap;
  logic [CH_OUT_W-1:0] start_ch;
  logic [RES_W-1:0]    result;

  adc_regs #(.RES_W(RES_W), .NUM_CH(NUM_CH), .CH_OUT_W(CH_OUT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .cap_i(cap), .result_i(result), .cfg_o(cfg),
    .start_o(start), .abort_o(abort), .start_ch_o(start_ch), .irq_o
  );

  adc_seq #(.RES_W(RES_W), .CH_OUT_W(CH_OUT_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort), .ch_i(start_ch),
    .done_i(conv_done_i), .data_i(conv_data_i), .busy_o(busy),
    .ch_o(conv_ch_o), .result_o(result), .cap_o(cap)
  );

  adc_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk_i, .rst_ni, .en_i(cfg.en), .div_i(cfg.div), .clk_o(conv_clk_o)
  );

  assign conv_start_o   = busy;
  assign conv_ref_int_o = cfg.ref_int;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cfg.ien); // R4
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
  localparam int RES_W = 10;
  localparam logic [31:0] RMASK = (32'd1 << RES_W) - 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq, cclk, cstart, cref;
  logic [2:0] cch;
  logic auto_done = 0, man_done = 0, use_man = 0, hold = 0;
  logic [RES_W-1:0] auto_data = 0, man_data = 0, last_data = 0;
  logic cdone;
  logic [RES_W-1:0] cdata;
  int lat = 3, cv_cnt = 0, seqn = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  assign cdone = use_man ? man_done : auto_done;
  assign cdata = use_man ? man_data : auto_data;

  always #4 clk = ~clk; // 125 MHz

  adc_conv_ctrl #(.RES_W(RES_W), .NUM_CH(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .conv_clk_o(cclk),
    .conv_start_o(cstart), .conv_ch_o(cch), .conv_ref_int_o(cref),
    .conv_done_i(cdone), .conv_data_i(cdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // converter model
  always begin
    @(posedge clk); #2;
    if (!cstart || hold) begin auto_done = 0; cv_cnt = 0; end
    else if (cv_cnt >= lat) begin
      seqn++;
      auto_done = 1;
      auto_data = RES_W'((int'(cch) * 37 + seqn * 11) & int'(RMASK));
      last_data = auto_data;
      cv_cnt = 0;
    end else begin auto_done = 0; cv_cnt++; end
  end

  // reference model
  logic [3:0] m_ch; logic m_ien, m_ref, m_en, m_rst, m_st, m_busy, m_cclk;
  logic [7:0] m_div; logic [2:0] m_lch; logic [31:0] m_res; int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ch = 0; m_ien = 0; m_ref = 0; m_en = 0; m_rst = 0; m_st = 0; m_busy = 0;
      m_cclk = 0; m_div = 0; m_lch = 0; m_res = 0; m_cnt = 0;
    end else begin
      bit wr, strt, cap, o_en; logic [7:0] o_div;
      o_en = m_en; o_div = m_div;
      wr = req && we && addr == 8'h00;
      if (wr) begin
        m_ch = wdata[27:24]; m_ien = wdata[21]; m_ref = wdata[19];
        m_en = wdata[17]; m_rst = wdata[16]; m_div = wdata[8:1];
      end
      cap  = m_busy && cdone && !m_rst;
      strt = wr && wdata[13] && wdata[17] && !wdata[16] && wdata[27:24] < 8;
      if (m_rst) m_busy = 0;
      else if (cap) begin m_busy = 0; m_res = 32'(cdata); end
      else if (!m_busy && strt) begin m_busy = 1; m_lch = wdata[26:24]; end
      if (cap) m_st = 1;
      else if (wr && wdata[18]) m_st = 0;
      if (!o_en) begin m_cnt = 0; m_cclk = 0; end
      else if (m_cnt >= int'(o_div)) begin m_cnt = 0; m_cclk = ~m_cclk; end
      else m_cnt++;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v = 0;
    if (a == 8'h00) begin
      v[27:24] = m_ch; v[21] = m_ien; v[19] = m_ref; v[18] = m_st;
      v[17] = m_en; v[16] = m_rst; v[13] = m_busy; v[8:1] = m_div;
    end else if (a == 8'h04) v = m_res & RMASK;
    return v;
  endfunction

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1 rdata", rdata, m_read(addr));
    chk("R2 start", 32'(cstart), 32'(m_busy));
    chk("R8 chan", 32'(cch), 32'(m_lch));
    chk("R4 irq", 32'(irq), 32'(m_st & m_ien));
    chk("R6 cclk", 32'(cclk), 32'(m_cclk));
    chk("R10 ref", 32'(cref), 32'(m_ref));
  end

  function automatic logic [31:0] mk(int ch, bit ien, bit rf, bit w1c, bit en,
                                     bit rs, bit cv, int dv);
    logic [31:0] v = 0;
    v[27:24] = 4'(ch); v[21] = ien; v[19] = rf; v[18] = w1c; v[17] = en;
    v[16] = rs; v[13] = cv; v[8:1] = 8'(dv);
    return v;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2; req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; req = 0; we = 0; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #2; addr = a; #1; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_irq(string tag);
    int k = 0;
    while (!irq && k < 300) begin @(negedge clk); k++; end
    chk(tag, 32'(irq), 32'd1);
  endtask

  task automatic summary;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung");
    summary();
  end

  initial begin
    logic [31:0] v;
    int t0, per;
    logic prev;
    repeat (4) @(posedge clk); #2; rst_n = 1;
    // R1 reset state
    rd(8'h00, v); chk("R1 reset ctrl", v, 0);
    rd(8'h04, v); chk("R1 reset result", v, 0);
    // R1 config readback, unmapped address
    wr(8'h00, mk(3, 1, 1, 0, 1, 0, 0, 2));
    rd(8'h00, v); chk("R1 readback", v, mk(3, 1, 1, 0, 1, 0, 0, 2));
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R1 unmapped", v, 0);
    rd(8'h00, v); chk("R1 unmapped write ignored", v, mk(3, 1, 1, 0, 1, 0, 0, 2));
    chk("R10 ref internal", 32'(cref), 1);
    // R6 period with div=2
    prev = cclk; t0 = -1; per = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cclk && !prev) begin
        if (t0 >= 0 && per == 0) per = i - t0;
        t0 = i;
      end
      prev = cclk;
    end
    chk("R6 period div2", per, 6);
    // R2/R3 conversion on channel 5
    wr(8'h00, mk(5, 1, 1, 0, 1, 0, 1, 2));
    rd(8'h00, v); chk("R2 conv bit", 32'(v[13]), 1);
    chk("R2 channel out", 32'(cch), 5);
    wait_irq("R3 irq on done");
    rd(8'h04, v); chk("R3 result", v, 32'(last_data));
    chk("R10 upper bits zero", v >> RES_W, 0);
    rd(8'h00, v); chk("R3 conv cleared", 32'(v[13]), 0);
    chk("R3 status set", 32'(v[18]), 1);
    // R4 W1C behaviour
    wr(8'h00, mk(5, 1, 1, 0, 1, 0, 0, 2));
    rd(8'h00, v); chk("R4 write0 keeps", 32'(v[18]), 1);
    wr(8'h00, mk(5, 0, 1, 0, 1, 0, 0, 2));
    chk("R4 irq masked", 32'(irq), 0);
    wr(8'h00, mk(5, 1, 1, 1, 1, 0, 0, 2));
    rd(8'h00, v); chk("R4 w1c clears", 32'(v[18]), 0);
    chk("R4 irq low", 32'(irq), 0);
    // R5 ignored starts
    wr(8'h00, mk(2, 1, 1, 0, 0, 0, 1, 2));
    rd(8'h00, v); chk("R5 disabled start", 32'(v[13]), 0);
    chk("R6 clk low disabled", 32'(cclk), 0);
    wr(8'h00, mk(9, 1, 1, 0, 1, 0, 1, 2));
    rd(8'h00, v); chk("R5 bad channel", 32'(v[13]), 0);
    chk("R5 no start line", 32'(cstart), 0);
    // R8 writes while busy
    lat = 20;
    wr(8'h00, mk(2, 1, 0, 0, 1, 0, 1, 0));
    chk("R10 ref external", 32'(cref), 0);
    wr(8'h00, mk(6, 1, 0, 0, 1, 0, 0, 0));
    rd(8'h00, v); chk("R8 conv0 no stop", 32'(v[13]), 1);
    chk("R8 channel held", 32'(cch), 2);
    wr(8'h00, mk(7, 1, 0, 0, 1, 0, 1, 0));
    chk("R8 no restart", 32'(cch), 2);
    wait_irq("R8 completes");
    rd(8'h04, v); chk("R8 result", v, 32'(last_data));
    lat = 3;
    // R9 stuck conversion, R7 soft reset
    hold = 1;
    wr(8'h00, mk(4, 1, 1, 1, 1, 0, 1, 1));
    idle(100);
    rd(8'h00, v); chk("R9 stuck conv", 32'(v[13]), 1);
    chk("R9 start held", 32'(cstart), 1);
    rd(8'h04, v); t0 = int'(v);
    wr(8'h00, mk(4, 1, 1, 0, 1, 1, 0, 1));
    rd(8'h00, v); chk("R7 abort", v, mk(4, 1, 1, 0, 1, 1, 0, 1));
    wr(8'h00, mk(4, 1, 1, 0, 1, 1, 1, 1));
    rd(8'h00, v); chk("R7 start ignored", 32'(v[13]), 0);
    rd(8'h04, v); chk("R7 no capture", v, 32'(t0));
    wr(8'h00, mk(4, 1, 1, 0, 1, 0, 0, 1));
    hold = 0;
    // R4 completion and clear in same cycle: set wins
    use_man = 1;
    wr(8'h00, mk(1, 1, 1, 0, 1, 0, 1, 1));
    idle(5);
    @(posedge clk); #2;
    man_done = 1; man_data = 10'h2A5;
    req = 1; we = 1; addr = 8'h00; wdata = mk(1, 1, 1, 1, 1, 0, 0, 1);
    @(posedge clk); #2;
    man_done = 0; req = 0; we = 0; wdata = 0;
    rd(8'h00, v); chk("R4 set wins", 32'(v[18]), 1);
    chk("R3 conv done", 32'(v[13]), 0);
    rd(8'h04, v); chk("R3 manual data", v, 32'h2A5);
    use_man = 0;
    // R6 div=0 period
    wr(8'h00, mk(0, 0, 1, 1, 1, 0, 0, 0));
    prev = cclk; t0 = -1; per = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cclk && !prev) begin
        if (t0 >= 0 && per == 0) per = i - t0;
        t0 = i;
      end
      prev = cclk;
    end
    chk("R6 period div0", per, 2);
    idle(3);
    summary();
  end
endmodule